// File: doc/BRIEF.md
# Quarter-Offset Manchester Bit Decoder

This block turns a clean, two-level Manchester line back into data bits. The bit period is known in advance and is given as a count of system clock cycles. The line is first brought into the clock domain, and then its transitions are detected. Every bit carries one mandatory transition in its middle. The decoder locks onto these mid-bit transitions and uses each one as a timing anchor for the bit that follows.

The decoder does not classify the direction of each edge. It samples the line a quarter period after the anchor, which is three quarters of the way into the bit. At that point any transition at the bit boundary lies in the past and the next mid-bit transition has not yet arrived. The level found there is the inverse of the level held before the edge, and that earlier level is the data bit. A polarity input selects which edge direction stands for a one.

After an anchor, all edges are ignored for three quarters of a period. The first edge after that window becomes the next anchor. If no edge arrives within one and a quarter periods, the decoder flags a timing error and drops lock. Lock is declared after a programmable number of consecutive well-spaced anchors. Bits are delivered only while the decoder is locked.

Top module: `mqd_decoder`

## Requirements
- R1: While reset is asserted (rst_n low), bit_o, bit_vld_o, locked_o and terr_o are all 0.
- R2: With fall_one_i = 1, a bit whose first half is high and second half is low (falling mid-bit edge) decodes as 1, and the opposite shape decodes as 0.
- R3: With fall_one_i = 0, a rising mid-bit edge decodes as 1 and a falling one as 0.
- R4: Each decoded bit appears with a one-cycle pulse on bit_vld_o, exactly period/4 + 4 clock cycles after the mid-bit edge on line_i. The 4 cycles are two synchronizer stages, one edge-detect stage and one output register.
- R5: Edges that arrive within three quarters of a period after an accepted anchor are ignored. This covers bit-boundary edges and short glitches after the mid-bit edge, and neither changes the decoded data.
- R6: If no edge is accepted within 1.25 periods of the last anchor, terr_o pulses for one cycle, exactly period + period/4 + 4 cycles after that mid-bit edge, and locked_o returns to 0.
- R7: From an unlocked state, the first edge is an anchor only. locked_o rises on the lock_n_i-th consecutive well-spaced anchor after it, and that anchor's bit is the first one delivered. A burst of len bits therefore yields len - lock_n_i decoded bits.
- R8: Runs of equal bits, which carry a transition at each bit boundary, decode correctly.
- R9: While locked_o is 0, bit_vld_o never pulses. A burst too short to reach lock produces no output bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Sliced Manchester line, asynchronous |
| period_i | input | CNT_W | Bit period in clock cycles |
| lock_n_i | input | LOCK_W | Number of well-spaced anchors needed for lock (at least 1) |
| fall_one_i | input | 1 | 1: a falling mid-bit edge means 1; 0: a rising one means 1 |
| bit_o | output | 1 | Decoded data bit |
| bit_vld_o | output | 1 | One-cycle strobe marking bit_o as valid |
| locked_o | output | 1 | Decoder is locked to the mid-bit transitions |
| terr_o | output | 1 | One-cycle pulse on a missing-transition timeout |

## Verification
The hardest case to reach from the ports is an edge that falls inside the blanking window but is not a bit-boundary edge. To create one, the stimulus injects a two-cycle glitch just after a mid-bit edge while the decoder is locked, then checks that the data stream and the strobe timing are unchanged. The lock threshold is also checked at its edge, using a burst exactly as long as the lock count. Every burst then ends with the line held still, so the timeout fires at a cycle position that can be checked against the last mid-bit edge.

// File: rtl/mqd_decoder.sv
module mqd_decoder #(
  parameter int CNT_W  = 12,
  parameter int LOCK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [LOCK_W-1:0] lock_n_i,
  input  logic              fall_one_i,
  output logic              bit_o,
  output logic              bit_vld_o,
  output logic              locked_o,
  output logic              terr_o
);
  localparam int EW = CNT_W + 1;

  logic              s1, s2, s3;
  logic              anch;
  logic [EW-1:0]     cnt;
  logic [LOCK_W-1:0] good;

  wire [EW-1:0] q1  = EW'(period_i >> 2);
  wire [EW-1:0] q3  = EW'(period_i) - q1;
  wire [EW-1:0] tmo = EW'(period_i) + q1;

  wire edg  = s2 ^ s3;
  wire acc  = edg && (!anch || cnt >= q3);
  wire tout = anch && !acc && cnt >= tmo;
  wire samp = locked_o && anch && !acc && cnt == q1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      anch <= 1'b0; cnt <= '0; good <= '0;
      locked_o <= 1'b0; terr_o <= 1'b0;
      bit_o <= 1'b0; bit_vld_o <= 1'b0;
    end else begin
      s1 <= line_i;
      s2 <= s1;
      s3 <= s2;
      terr_o    <= 1'b0;
      bit_vld_o <= 1'b0;
      if (acc) begin
        anch <= 1'b1;
        cnt  <= '0;
        if (anch) begin
          if (good != '1) good <= good + 1'b1;
          if (({1'b0, good} + 1'b1) >= {1'b0, lock_n_i}) locked_o <= 1'b1;
        end else begin
          good <= '0;
        end
      end else if (tout) begin
        anch     <= 1'b0;
        cnt      <= '0;
        good     <= '0;
        locked_o <= 1'b0;
        terr_o   <= 1'b1;
      end else if (anch) begin
        cnt <= cnt + 1'b1;
      end
      if (samp) begin
        bit_vld_o <= 1'b1;
        bit_o     <= fall_one_i ? ~s2 : s2;
      end
    end
  end

  p_vld_needs_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_o |-> $past(locked_o));
  p_vld_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_o |=> !bit_vld_o);
  p_err_unlocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    terr_o |-> !locked_o);
  p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    terr_o |=> !terr_o);
  p_blank_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (anch && edg && cnt < q3 && cnt < tmo) |=> (cnt == $past(cnt) + 1'b1));
  p_lock_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(edg));
endmodule

// File: tb/mqd_decoder_tb.sv
module mqd_decoder_tb;
  localparam int T    = 16;
  localparam int HALF = T / 2;
  localparam int NV   = 6;
  localparam int VDLY = T / 4 + 4;
  localparam int EDLY = T + T / 4 + 4;

  localparam bit          V_POL  [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam int          V_LOCK [NV] = '{2, 2, 4, 1, 3, 3};
  localparam int          V_LEN  [NV] = '{12, 12, 16, 10, 3, 8};
  localparam logic [15:0] V_BITS [NV] = '{16'h0B38, 16'h0C5D, 16'hFFFF,
                                          16'h0155, 16'h0005, 16'h0000};

  logic clk = 1'b0, rst_n = 1'b0, line = 1'b0, fall_one = 1'b1;
  logic [11:0] period = 12'(T);
  logic [3:0]  lock_n = 4'd2;
  logic bit_o, bit_vld, locked, terr;

  int nchk = 0, nfail = 0, cyc = 0;
  int rx_n, err_n, err_cyc;
  logic rx [32];
  int   rx_cyc [32];
  int   mid_cyc [32];

  always #5 clk = ~clk;

  mqd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .line_i(line), .period_i(period),
    .lock_n_i(lock_n), .fall_one_i(fall_one),
    .bit_o(bit_o), .bit_vld_o(bit_vld), .locked_o(locked), .terr_o(terr)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (bit_vld && rx_n < 32) begin
      rx[rx_n] <= bit_o;
      rx_cyc[rx_n] <= cyc;
      rx_n <= rx_n + 1;
    end
    if (terr) begin
      err_n <= err_n + 1;
      err_cyc <= cyc;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input bit pol, input int lk, input int len,
                         input logic [15:0] bits, input int glitch_at);
    logic first;
    int exp_n, bad_bit, bad_dly, first_bad;
    fall_one = pol;
    lock_n   = 4'(lk);
    line     = pol ? bits[0] : ~bits[0];
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check({bit_o, bit_vld, locked, terr} == 4'b0000, "R1 reset outputs",
          int'({bit_o, bit_vld, locked, terr}), 0);
    rst_n = 1'b1;
    repeat (3 * T) @(negedge clk);
    rx_n = 0; err_n = 0; err_cyc = 0;
    for (int i = 0; i < len; i++) begin
      first = pol ? bits[i] : ~bits[i];
      line = first;
      repeat (HALF) @(negedge clk);
      line = ~first;
      mid_cyc[i] = cyc;
      if (i == glitch_at) begin
        @(negedge clk) line = first;
        @(negedge clk) line = ~first;
        repeat (HALF - 2) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
    end
    repeat (3 * T) @(negedge clk);
    exp_n = (len > lk) ? len - lk : 0;
    check(rx_n == exp_n, (exp_n == 0) ? "R9 no output before lock" : "R7 bit count after lock",
          rx_n, exp_n);
    bad_bit = 0; bad_dly = 0; first_bad = -1;
    for (int i = 0; i < rx_n && i < exp_n; i++) begin
      if (rx[i] !== bits[lk + i]) begin
        bad_bit++;
        if (first_bad < 0) first_bad = i;
      end
      if (rx_cyc[i] - mid_cyc[lk + i] != VDLY) bad_dly++;
    end
    if (exp_n > 0) begin
      check(bad_bit == 0, pol ? "R2 R8 R5 data (fall=1)" : "R3 R8 data (fall=0)",
            first_bad, -1);
      check(bad_dly == 0, "R4 strobe delay", bad_dly, 0);
    end
    check(err_n == 1, "R6 one timeout pulse", err_n, 1);
    check(err_cyc - mid_cyc[len - 1] == EDLY, "R6 timeout position",
          err_cyc - mid_cyc[len - 1], EDLY);
    check(locked == 1'b0, "R6 lock dropped", int'(locked), 0);
  endtask

  initial begin
    rx_n = 0; err_n = 0; err_cyc = 0;
    repeat (4) @(negedge clk);
    for (int v = 0; v < NV; v++)
      run_vec(V_POL[v], V_LOCK[v], V_LEN[v], V_BITS[v], -1);
    // R5: glitch right after a locked mid-bit edge
    run_vec(1'b1, 1, 10, 16'h02D6, 4);
    // R5 with opposite polarity and a glitch in a run of equal bits
    run_vec(1'b0, 2, 9, 16'h01E3, 5);
    // R7 lock threshold exactly met: len = lock + 1 gives one bit
    run_vec(1'b1, 5, 6, 16'h0021, -1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule